// File: doc/BRIEF.md
# Read-Path Byte Parity Generator

This block is the output stage of one port of a 36-bit synchronous FIFO that also carries a one-word mailbox. On a rising port-clock edge where the port is reading, the output register loads either the FIFO word presented by the memory or the word held in the mailbox register. The word is split into four 9-bit lanes. Bits 9k+7 down to 9k of lane k are data and bit 9k+8 is the parity position. When parity generation is requested for the read, every lane's parity position is recomputed from its eight data bits and replaces the stored bit. Otherwise the word passes through untouched.

The port keeps two sets of lane parity trees. One set sits on the memory read path, between the memory word and the output register. The other set normally checks the nine bits of each lane on the port's input bus and drives a registered per-lane error flag. During a mailbox read with generation on, that second set is taken over to compute the mailbox word's parity, and the error flags hold their value. The mailbox register is written from the far side of the FIFO. Reading it, with or without generation, never alters it.

Top module: `lpar_port`

## Requirements
- R1: A synchronous active-high `rst` clears `dout`, `perr` and the mailbox register to zero by the next rising edge.
- R2: A FIFO load happens on an edge where `wr_rdn`=0, `csel_n`=0, `en`=1, `mbox_sel`=0 and `fifo_avail`=1. With `pgen`=0, `dout` then holds `mem_word` exactly, including the bits at positions 8, 17, 26 and 35.
- R3: On a FIFO load with `pgen`=1, `dout` bit 9k+8 is replaced by generated parity for each lane k in 0..3, and bits 9k+7..9k are copied. With `odd_sel`=1 the lane's nine bits hold an odd number of ones. With `odd_sel`=0 they hold an even number.
- R4: A mailbox load happens on an edge where `wr_rdn`=0, `csel_n`=0, `en`=1 and `mbox_sel`=1. `dout` then takes the mailbox word. When `pgen`=1 as well, the lane parity positions are substituted as in R3 using `odd_sel`.
- R5: A mailbox load with generation leaves the mailbox register unchanged. A later mailbox load with `pgen`=0 returns the word originally written.
- R6: On an edge with no load, `dout` keeps its value whatever `pgen`, `odd_sel`, `mem_word` or the mailbox contents do.
- R7: There is no load when `csel_n`=1, when `en`=0 or when `wr_rdn`=1. With `mbox_sel`=0 and `fifo_avail`=0 there is also no load.
- R8: On every edge that is not a mailbox generation edge (R4 conditions together with `pgen`=1), `perr[k]` is loaded with the check result for lane k of `bus_in`. The flag is 1 when the ones-count of bits 9k+8..9k is even while `odd_sel`=1, or odd while `odd_sel`=0.
- R9: On a mailbox generation edge, `perr` keeps its previous value whatever `bus_in` carries.
- R10: `mbox_wr`=1 on an edge stores `mbox_wdata` in the mailbox register. A mailbox load on that same edge returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| csel_n | input | 1 | Chip select, active low |
| wr_rdn | input | 1 | Direction select, 0 = read, 1 = write |
| en | input | 1 | Port enable, active high |
| mbox_sel | input | 1 | 1 = mailbox access, 0 = FIFO access |
| pgen | input | 1 | Parity generation request for a read |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_avail | input | 1 | A FIFO word is available to load |
| mem_word | input | 36 | Word leaving the FIFO memory |
| mbox_wr | input | 1 | Far-side mailbox write strobe |
| mbox_wdata | input | 36 | Far-side mailbox write data |
| bus_in | input | 36 | Port input bus, checked for parity |
| dout | output | 36 | Output register |
| perr | output | 4 | Registered per-lane parity error flags |

## Verification
The bench covers words whose data bytes have both even and odd ones-counts under both parity senses, including all-zero and all-one words. A swapped sense or a wrong lane boundary would show up there as a flipped parity position in `dout`. It performs a generating mailbox read followed by a plain one, so a design that writes generated bits back into the mailbox returns altered parity positions on the second read. It changes `pgen`, `odd_sel` and the source words on edges where one of the decode terms blocks the load, which catches a register that reloads or re-derives parity outside a load. It also drives bus words with lane errors during mailbox generation, so check flags that keep updating while the shared trees are busy are reported.

// File: rtl/lpar_pkg.sv
package lpar_pkg;

    // Which source the output register takes on this edge
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_MBOX = 2'd2
    } load_src_e;

    // Decoded port control for one cycle
    typedef struct packed {
        logic      rd;        // port selected, enabled, reading
        logic      mbox_gen;  // shared trees generate for the mailbox
        logic      chk_en;    // shared trees check the input bus
        logic      pgen;      // substitute parity on this load
        load_src_e src;
    } port_ctl_t;

    // Parity position value that gives the requested sense over a lane
    function automatic logic gen_bit(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction

    // Error when the nine-bit reduction disagrees with the requested sense
    function automatic logic lane_bad(input logic lane_xor, input logic odd);
        return lane_xor ^ odd;
    endfunction

endpackage

// File: rtl/lpar_ctl_dec.sv
module lpar_ctl_dec
    import lpar_pkg::*;
(
    input  logic      csel_n,
    input  logic      wr_rdn,
    input  logic      en,
    input  logic      mbox_sel,
    input  logic      fifo_avail,
    input  logic      pgen,
    output port_ctl_t ctl
);
    logic rd;

    assign rd = !csel_n && !wr_rdn && en;

    always_comb begin
        ctl          = '0;
        ctl.rd       = rd;
        ctl.pgen     = pgen;
        ctl.mbox_gen = rd && mbox_sel && pgen;
        ctl.chk_en   = !(rd && mbox_sel && pgen);
        if (rd && mbox_sel) begin
            ctl.src = SRC_MBOX;
        end else if (rd && fifo_avail) begin
            ctl.src = SRC_FIFO;
        end else begin
            ctl.src = SRC_HOLD;
        end
    end
endmodule

// File: rtl/lpar_lane_tree.sv
module lpar_lane_tree
    import lpar_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    localparam int unsigned LANE_W   = DATA_BITS + 1
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              odd,
    output logic [LANE_W-1:0] lane_gen,
    output logic              lane_err
);
    logic data_x;

    // The eight-bit reduction is shared by generation and checking
    assign data_x   = ^lane_in[DATA_BITS-1:0];
    assign lane_gen = {gen_bit(data_x, odd), lane_in[DATA_BITS-1:0]};
    assign lane_err = lane_bad(data_x ^ lane_in[DATA_BITS], odd);
endmodule

// File: rtl/lpar_word_trees.sv
module lpar_word_trees #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned DATA_BITS = 8,
    localparam int unsigned LANE_W   = DATA_BITS + 1,
    localparam int unsigned WORD_W   = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              odd,
    output logic [WORD_W-1:0] word_gen,
    output logic [LANES-1:0]  lane_err
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lpar_lane_tree #(.DATA_BITS(DATA_BITS)) u_tree (
            .lane_in (word_in[k*LANE_W +: LANE_W]),
            .odd     (odd),
            .lane_gen(word_gen[k*LANE_W +: LANE_W]),
            .lane_err(lane_err[k])
        );
    end
endmodule

// File: rtl/lpar_mbox_reg.sv
module lpar_mbox_reg #(
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/lpar_out_stage.sv
module lpar_out_stage
    import lpar_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ctl_t         ctl,
    input  logic [WORD_W-1:0] fifo_raw,
    input  logic [WORD_W-1:0] fifo_gen,
    input  logic [WORD_W-1:0] mbox_raw,
    input  logic [WORD_W-1:0] mbox_gen,
    input  logic [LANES-1:0]  chk_err,
    output logic [WORD_W-1:0] dout,
    output logic [LANES-1:0]  perr
);
    logic [WORD_W-1:0] next_word;

    always_comb begin
        unique case (ctl.src)
            SRC_FIFO: next_word = ctl.pgen ? fifo_gen : fifo_raw;
            SRC_MBOX: next_word = ctl.pgen ? mbox_gen : mbox_raw;
            default:  next_word = dout;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            perr <= '0;
        end else begin
            dout <= next_word;
            if (ctl.chk_en) begin
                perr <= chk_err;
            end
        end
    end
endmodule

// File: rtl/lpar_port.sv
module lpar_port
    import lpar_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter int unsigned DATA_BITS = 8,
    localparam int unsigned LANE_W   = DATA_BITS + 1,
    localparam int unsigned WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csel_n,
    input  logic              wr_rdn,
    input  logic              en,
    input  logic              mbox_sel,
    input  logic              pgen,
    input  logic              odd_sel,
    input  logic              fifo_avail,
    input  logic [WORD_W-1:0] mem_word,
    input  logic              mbox_wr,
    input  logic [WORD_W-1:0] mbox_wdata,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] dout,
    output logic [LANES-1:0]  perr
);
    port_ctl_t         ctl;
    logic [WORD_W-1:0] mbox_q;
    logic [WORD_W-1:0] fifo_gen;
    logic [LANES-1:0]  fifo_err_unused;
    logic [WORD_W-1:0] shared_in;
    logic [WORD_W-1:0] shared_gen;
    logic [LANES-1:0]  shared_err;

    lpar_ctl_dec u_dec (
        .csel_n    (csel_n),
        .wr_rdn    (wr_rdn),
        .en        (en),
        .mbox_sel  (mbox_sel),
        .fifo_avail(fifo_avail),
        .pgen      (pgen),
        .ctl       (ctl)
    );

    lpar_mbox_reg #(.WORD_W(WORD_W)) u_mbox (
        .clk  (clk),
        .rst  (rst),
        .wr   (mbox_wr),
        .wdata(mbox_wdata),
        .q    (mbox_q)
    );

    // Trees on the memory read path, ahead of the output register
    lpar_word_trees #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_fifo_trees (
        .word_in (mem_word),
        .odd     (odd_sel),
        .word_gen(fifo_gen),
        .lane_err(fifo_err_unused)
    );

    // Bus check trees, borrowed for mailbox generation
    assign shared_in = ctl.mbox_gen ? mbox_q : bus_in;

    lpar_word_trees #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_shared_trees (
        .word_in (shared_in),
        .odd     (odd_sel),
        .word_gen(shared_gen),
        .lane_err(shared_err)
    );

    lpar_out_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .fifo_raw(mem_word),
        .fifo_gen(fifo_gen),
        .mbox_raw(mbox_q),
        .mbox_gen(shared_gen),
        .chk_err (shared_err),
        .dout    (dout),
        .perr    (perr)
    );
endmodule

// File: rtl/lpar_port_chk.sv
module lpar_port_chk #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned DATA_BITS = 8,
    localparam int unsigned LANE_W   = DATA_BITS + 1,
    localparam int unsigned WORD_W   = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              csel_n,
    input logic              wr_rdn,
    input logic              en,
    input logic              mbox_sel,
    input logic              pgen,
    input logic              odd_sel,
    input logic              fifo_avail,
    input logic [WORD_W-1:0] mem_word,
    input logic [WORD_W-1:0] bus_in,
    input logic [WORD_W-1:0] dout,
    input logic [LANES-1:0]  perr
);
    logic rd_c, load_c, fifo_c, gen_c;

    assign rd_c   = !csel_n && !wr_rdn && en;
    assign fifo_c = rd_c && !mbox_sel && fifo_avail;
    assign load_c = rd_c && (mbox_sel || fifo_avail);
    assign gen_c  = rd_c && mbox_sel && pgen;

    function automatic logic sense_ok(input logic [WORD_W-1:0] w, input logic odd);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if ((^w[k*LANE_W +: LANE_W]) != odd) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [LANES-1:0] bus_flags(input logic [WORD_W-1:0] w, input logic odd);
        logic [LANES-1:0] f;
        for (int k = 0; k < LANES; k++) begin
            f[k] = (^w[k*LANE_W +: LANE_W]) != odd;
        end
        return f;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dout == '0 && perr == '0));

    assert_fifo_raw_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_c && !pgen) |=> dout == $past(mem_word));

    assert_lane_sense_R3: assert property (@(posedge clk) disable iff (rst)
        (load_c && pgen) |=> sense_ok(dout, $past(odd_sel)));

    assert_hold_no_load_R6: assert property (@(posedge clk) disable iff (rst)
        !load_c |=> $stable(dout));

    assert_bus_check_R8: assert property (@(posedge clk) disable iff (rst)
        !gen_c |=> perr == bus_flags($past(bus_in), $past(odd_sel)));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        gen_c |=> $stable(perr));
endmodule

bind lpar_port lpar_port_chk #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csel_n    (csel_n),
    .wr_rdn    (wr_rdn),
    .en        (en),
    .mbox_sel  (mbox_sel),
    .pgen      (pgen),
    .odd_sel   (odd_sel),
    .fifo_avail(fifo_avail),
    .mem_word  (mem_word),
    .bus_in    (bus_in),
    .dout      (dout),
    .perr      (perr)
);

// File: tb/tb_lpar_port.sv
module tb_lpar_port;
    localparam int W = 36;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         csel_n = 1'b1, wr_rdn = 1'b1, en = 1'b0, mbox_sel = 1'b0;
    logic         pgen = 1'b0, odd_sel = 1'b0, fifo_avail = 1'b0, mbox_wr = 1'b0;
    logic [W-1:0] mem_word = '0, mbox_wdata = '0, bus_in = '0;
    logic [W-1:0] dout;
    logic [L-1:0] perr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state
    logic [W-1:0] m_dout = '0, m_mbox = '0;
    logic [L-1:0] m_perr = '0;

    always #2 clk = ~clk;

    lpar_port dut (
        .clk(clk), .rst(rst), .csel_n(csel_n), .wr_rdn(wr_rdn), .en(en),
        .mbox_sel(mbox_sel), .pgen(pgen), .odd_sel(odd_sel),
        .fifo_avail(fifo_avail), .mem_word(mem_word), .mbox_wr(mbox_wr),
        .mbox_wdata(mbox_wdata), .bus_in(bus_in), .dout(dout), .perr(perr)
    );

    function automatic int ones(input logic [W-1:0] w, input int lo, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (w[lo+i]) c++;
        return c;
    endfunction

    function automatic logic [W-1:0] with_parity(input logic [W-1:0] w, input logic odd);
        logic [W-1:0] r = w;
        for (int k = 0; k < L; k++) begin
            // odd sense: set the bit when the data count is even
            r[9*k+8] = odd ? ((ones(w, 9*k, 8) % 2) == 0) : ((ones(w, 9*k, 8) % 2) == 1);
        end
        return r;
    endfunction

    function automatic logic [L-1:0] flags(input logic [W-1:0] w, input logic odd);
        logic [L-1:0] f;
        for (int k = 0; k < L; k++) begin
            f[k] = odd ? ((ones(w, 9*k, 9) % 2) == 0) : ((ones(w, 9*k, 9) % 2) == 1);
        end
        return f;
    endfunction

    task automatic step(input string tag);
        logic [W-1:0] nd, nm;
        logic [L-1:0] np;
        logic rd;
        rd = !csel_n && !wr_rdn && en;
        nd = m_dout; nm = m_mbox; np = m_perr;
        if (rst) begin
            nd = '0; nm = '0; np = '0;
        end else begin
            if (mbox_wr) nm = mbox_wdata;
            if (rd && mbox_sel) nd = pgen ? with_parity(m_mbox, odd_sel) : m_mbox;
            else if (rd && fifo_avail) nd = pgen ? with_parity(mem_word, odd_sel) : mem_word;
            if (!(rd && mbox_sel && pgen)) np = flags(bus_in, odd_sel);
        end
        @(posedge clk);
        m_dout = nd; m_mbox = nm; m_perr = np;
        @(negedge clk);
        checks++;
        if (dout !== m_dout) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", tag, dout, m_dout);
        end
        checks++;
        if (perr !== m_perr) begin
            errors++;
            $display("FAIL %s perr actual %b expected %b", tag, perr, m_perr);
        end
    endtask

    task automatic idle();
        csel_n = 1'b1; wr_rdn = 1'b1; en = 1'b0; mbox_sel = 1'b0;
        fifo_avail = 1'b0; mbox_wr = 1'b0;
    endtask

    task automatic fifo_rd(input logic [W-1:0] w, input logic g, input logic o, input string tag);
        csel_n = 1'b0; wr_rdn = 1'b0; en = 1'b1; mbox_sel = 1'b0; fifo_avail = 1'b1;
        mem_word = w; pgen = g; odd_sel = o;
        step(tag);
        idle();
    endtask

    task automatic mbox_rd(input logic g, input logic o, input string tag);
        csel_n = 1'b0; wr_rdn = 1'b0; en = 1'b1; mbox_sel = 1'b1;
        pgen = g; odd_sel = o;
        step(tag);
        idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        mem_word = 36'hFFFFFFFFF; bus_in = 36'h123456789;
        step("R1"); step("R1");
        rst = 1'b0;
        mbox_rd(1'b0, 1'b0, "R1");           // mailbox reads zero after reset

        // R2: raw FIFO loads keep parity positions
        fifo_rd(36'h9_0000_0001, 1'b0, 1'b1, "R2");
        fifo_rd(36'hF_FFFF_FFFF, 1'b0, 1'b0, "R2");
        fifo_rd(36'h0_8040_2010, 1'b0, 1'b1, "R2");

        // R3: generated parity, both senses
        fifo_rd(36'h0_0000_0000, 1'b1, 1'b1, "R3");
        fifo_rd(36'h0_0000_0000, 1'b1, 1'b0, "R3");
        fifo_rd(36'hF_FFFF_FFFF, 1'b1, 1'b1, "R3");
        fifo_rd(36'hF_FFFF_FFFF, 1'b1, 1'b0, "R3");
        fifo_rd(36'h1_0203_0407, 1'b1, 1'b1, "R3");
        fifo_rd(36'hA_5A5A_5A5A, 1'b1, 1'b0, "R3");

        // R7: blocked loads
        mem_word = 36'h3_3333_3333; pgen = 1'b1; odd_sel = 1'b1; fifo_avail = 1'b1;
        csel_n = 1'b1; wr_rdn = 1'b0; en = 1'b1; step("R7");
        csel_n = 1'b0; en = 1'b0; step("R7");
        en = 1'b1; wr_rdn = 1'b1; step("R7");
        wr_rdn = 1'b0; fifo_avail = 1'b0; step("R7");
        idle();

        // R6: select changes on idle edges
        fifo_rd(36'h5_1234_5678, 1'b1, 1'b0, "R6");
        pgen = 1'b0; odd_sel = 1'b1; mem_word = 36'h0_0000_00FF; step("R6");
        pgen = 1'b1; odd_sel = 1'b0; step("R6");

        // R10: mailbox write; same-edge read returns old value
        mbox_wdata = 36'hC_0FFE_E123; mbox_wr = 1'b1; step("R10");
        mbox_wr = 1'b0;
        mbox_rd(1'b0, 1'b0, "R10");
        mbox_wdata = 36'h7_7777_7777; mbox_wr = 1'b1;
        csel_n = 1'b0; wr_rdn = 1'b0; en = 1'b1; mbox_sel = 1'b1; pgen = 1'b0;
        step("R10");
        idle();

        // R4 and R5: generated mailbox reads, then plain read
        mbox_rd(1'b1, 1'b1, "R4");
        mbox_rd(1'b1, 1'b0, "R4");
        mbox_rd(1'b0, 1'b0, "R5");

        // R8: bus checks under both senses
        bus_in = 36'h0_0000_0000; odd_sel = 1'b1; step("R8");
        odd_sel = 1'b0; step("R8");
        bus_in = 36'h1_0000_0201; step("R8");
        odd_sel = 1'b1; step("R8");
        mbox_rd(1'b0, 1'b1, "R8");           // plain mailbox read keeps checking

        // R9: flags frozen while trees generate for the mailbox
        bus_in = 36'h0_0000_0001; odd_sel = 1'b0; step("R9");
        csel_n = 1'b0; wr_rdn = 1'b0; en = 1'b1; mbox_sel = 1'b1; pgen = 1'b1;
        bus_in = 36'hF_FFFF_FFFF; step("R9");
        bus_in = 36'h0_0000_0000; odd_sel = 1'b1; step("R9");
        idle(); step("R9");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            csel_n = $urandom_range(0, 3) == 0;
            wr_rdn = $urandom_range(0, 3) == 0;
            en = $urandom_range(0, 4) != 0;
            mbox_sel = $urandom_range(0, 2) == 0;
            fifo_avail = $urandom_range(0, 3) != 0;
            pgen = $urandom_range(0, 1) == 1;
            odd_sel = $urandom_range(0, 1) == 1;
            mbox_wr = $urandom_range(0, 5) == 0;
            mem_word = {$urandom(), $urandom()} & {W{1'b1}};
            mbox_wdata = {$urandom(), $urandom()} & {W{1'b1}};
            bus_in = {$urandom(), $urandom()} & {W{1'b1}};
            rst = $urandom_range(0, 99) == 0;
            step("R3");
        end
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule